// File: doc/BRIEF.md
# Locked Indexed Configuration Port

This block is the configuration entry point of a legacy I/O controller. It sits on a plain 8-bit I/O bus with an address, a write strobe, a read strobe and separate write and read data. It answers at two consecutive addresses: an index address (the `BASE_ADDR` parameter) and a data address (`BASE_ADDR + 1`). After reset the pair is sealed. A key byte written to the index address opens it, and a second key byte seals it again.

While the port is open, any other byte written to the index address selects one of 256 byte-wide configuration registers. The data address then reads or writes the selected register. One bit of one register, bit 7 of register 0xC1, is copied to a level output that switches on a secondary plug-and-play register window. That copy is refreshed every time the data register is written.

A two-state machine holds the seal. In state `ST_LOCKED` (entered on reset), transition UNLOCK moves to `ST_OPEN` when 0xAA is written to the index address. In `ST_OPEN`, transition RELOCK returns to `ST_LOCKED` when 0x55 is written to the index address. Every other event leaves the state where it is.

Top module: `cfgport_top`

## Requirements
- R1: After reset the port is in `ST_LOCKED`, `pnp_win_en` is 0, and reads at both addresses return 0xFF.
- R2: In `ST_LOCKED`, the only write with any effect is 0xAA to the index address. Writes of other values to the index address (including 0x55), and any write to the data address, leave the state, the index and all registers unchanged.
- R3: In `ST_OPEN`, writing 0x55 to the index address returns the port to `ST_LOCKED`. The current index keeps its value across lock and unlock.
- R4: In `ST_OPEN`, writing any value other than 0x55 to the index address makes that value the current index. A read of the index address returns the current index.
- R5: In `ST_OPEN`, a write to the data address stores the byte in the register selected by the current index. A read of the data address returns that register. Each register holds its own value.
- R6: In `ST_LOCKED`, a read of either address returns 0xFF. A cycle without the read strobe also shows 0xFF on `io_rdata`.
- R7: On the clock edge that takes a data-address write in `ST_OPEN`, `pnp_win_en` is loaded with bit 7 of register 0xC1 as it stands after that write.
- R8: Reset clears the current index and all 256 registers to 0x00.
- R9: Accesses at any address other than the index and data addresses have no effect on state, index, registers or `pnp_win_en`, and reads there return 0xFF.
- R10: In `ST_OPEN`, writing 0xAA to the index address is an ordinary index write: the index becomes 0xAA and the port stays open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational, 0xFF when not driven by the port |
| pnp_win_en | output | 1 | Enable for the plug-and-play register window |

## Verification
The embedded assertions check the following on every cycle:
- both lock-state transitions and their absence on non-key index writes in `ST_LOCKED`;
- the index load;
- write-then-read coherence of the selected register;
- 0xFF returned while sealed or off-address;
- the window enable following a direct write to register 0xC1.

Some behaviours only the bench scenarios can show:
- that writes made while sealed leave no trace once the port is reopened;
- that the index survives a lock/unlock round trip;
- that registers do not alias one another;
- that reset clears stored contents, not just the state.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_t;

    localparam logic [7:0] KEY_UNLOCK = 8'hAA;
    localparam logic [7:0] KEY_LOCK   = 8'h55;
    localparam logic [7:0] IDLE_READ  = 8'hFF;

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode #(
    parameter int              AW        = 16,
    parameter logic [AW-1:0]   BASE_ADDR = 16'h0108
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    output logic          idx_wr,
    output logic          dat_wr,
    output logic          idx_rd,
    output logic          dat_rd
);
    localparam logic [AW-1:0] DATA_ADDR = BASE_ADDR + AW'(1);

    logic hit_idx;
    logic hit_dat;

    always_comb begin
        hit_idx = (addr == BASE_ADDR);
        hit_dat = (addr == DATA_ADDR);
        idx_wr  = wr & hit_idx;
        dat_wr  = wr & hit_dat;
        idx_rd  = rd & hit_idx;
        dat_rd  = rd & hit_dat;
    end

endmodule

// File: rtl/cfgport_lock_fsm.sv
module cfgport_lock_fsm
    import cfgport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [DW-1:0] wdata,
    output logic          open
);
    lock_state_t state_q;
    lock_state_t state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (idx_wr && wdata == KEY_UNLOCK) state_d = ST_OPEN;
            ST_OPEN:   if (idx_wr && wdata == KEY_LOCK)   state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        open = (state_q == ST_OPEN);
    end

    // R2
    unlock_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && idx_wr && wdata == KEY_UNLOCK) |=> open);
    // R2
    stay_sealed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && !(idx_wr && wdata == KEY_UNLOCK)) |=> !open);
    // R3
    relock_on_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open && idx_wr && wdata == KEY_LOCK) |=> !open);
    // R10
    open_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open && !(idx_wr && wdata == KEY_LOCK)) |=> open);

endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile #(
    parameter int          DW      = 8,
    parameter logic [7:0]  WIN_REG = 8'hC1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_we,
    input  logic          dat_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] idx_q,
    output logic [DW-1:0] sel_q,
    output logic [DW-1:0] win_q
);
    localparam int NREG = 1 << DW;

    logic [DW-1:0] cells [NREG];

    // current index register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= wdata;
    end

    // one byte cell per register
    for (genvar g = 0; g < NREG; g++) begin : g_cell
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (dat_we && idx_q == DW'(g))      q <= wdata;
        end
        assign cells[g] = q;
    end

    always_comb begin
        sel_q = cells[idx_q];
        win_q = cells[WIN_REG];
    end

    // R4
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> idx_q == $past(wdata));
    // R5
    cell_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !idx_we) |=> sel_q == $past(wdata));

endmodule

// File: rtl/cfgport_window.sv
module cfgport_window #(
    parameter int          DW      = 8,
    parameter logic [7:0]  WIN_REG = 8'hC1,
    parameter int          WIN_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dat_we,
    input  logic [DW-1:0] idx_q,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] win_q,
    output logic          win_en
);
    logic next_bit;

    always_comb begin
        next_bit = (idx_q == WIN_REG) ? wdata[WIN_BIT] : win_q[WIN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      win_en <= 1'b0;
        else if (dat_we) win_en <= next_bit;
    end

    // R7
    win_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && idx_q == WIN_REG) |=> win_en == $past(wdata[WIN_BIT]));

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int              AW        = 16,
    parameter int              DW        = 8,
    parameter logic [AW-1:0]   BASE_ADDR = 16'h0108,
    parameter logic [7:0]      WIN_REG   = 8'hC1,
    parameter int              WIN_BIT   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [7:0]    io_wdata,
    output logic [7:0]    io_rdata,
    output logic          pnp_win_en
);
    logic          idx_wr, dat_wr, idx_rd, dat_rd;
    logic          open;
    logic          idx_we, dat_we;
    logic [DW-1:0] idx_q, sel_q, win_q;

    cfgport_decode #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr   (io_addr),
        .wr     (io_wr),
        .rd     (io_rd),
        .idx_wr (idx_wr),
        .dat_wr (dat_wr),
        .idx_rd (idx_rd),
        .dat_rd (dat_rd)
    );

    cfgport_lock_fsm #(.DW(DW)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .wdata  (io_wdata),
        .open   (open)
    );

    always_comb begin
        idx_we = open & idx_wr & (io_wdata != KEY_LOCK);
        dat_we = open & dat_wr;
    end

    cfgport_regfile #(.DW(DW), .WIN_REG(WIN_REG)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_we (idx_we),
        .dat_we (dat_we),
        .wdata  (io_wdata),
        .idx_q  (idx_q),
        .sel_q  (sel_q),
        .win_q  (win_q)
    );

    cfgport_window #(.DW(DW), .WIN_REG(WIN_REG), .WIN_BIT(WIN_BIT)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .dat_we (dat_we),
        .idx_q  (idx_q),
        .wdata  (io_wdata),
        .win_q  (win_q),
        .win_en (pnp_win_en)
    );

    always_comb begin
        io_rdata = IDLE_READ;
        if (open) begin
            if (idx_rd)      io_rdata = idx_q;
            else if (dat_rd) io_rdata = sel_q;
        end
    end

    // R6
    sealed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !open) |-> io_rdata == IDLE_READ);
    // R9
    off_addr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr != BASE_ADDR && io_addr != BASE_ADDR + 16'd1)
            |-> io_rdata == IDLE_READ);
    // R9
    off_addr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr != BASE_ADDR && io_addr != BASE_ADDR + 16'd1)
            |=> $stable(pnp_win_en));

endmodule

// File: tb/cfgport_top_tb.sv
module cfgport_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] IDX = 16'h0108;
    localparam logic [15:0] DAT = 16'h0109;

    typedef struct {
        logic [7:0] exp;
        string      req;
        bit         pnp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        pnp_win_en;
    logic        probe = 1'b0;

    item_t q_exp[$];
    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgport_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .pnp_win_en (pnp_win_en)
    );

    // monitor: compares each observed result with the oldest expectation
    always @(negedge clk) begin
        if (io_rd || probe) begin
            logic [7:0] got;
            got = probe ? {7'b0, pnp_win_en} : io_rdata;
            n_vec++;
            if (q_exp.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: actual %02h expected none", got);
            end else begin
                item_t it;
                it = q_exp.pop_front();
                if (got !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", it.req, got, it.exp);
                end
            end
        end
    end

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, input logic [7:0] e, input string r);
        item_t it;
        it.exp = e; it.req = r; it.pnp = 1'b0;
        @(posedge clk); #1;
        q_exp.push_back(it);
        io_addr = a; io_rd = 1'b1;
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic win_chk(input logic e, input string r);
        item_t it;
        it.exp = {7'b0, e}; it.req = r; it.pnp = 1'b1;
        @(posedge clk); #1;
        q_exp.push_back(it);
        probe = 1'b1;
        @(posedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 / R6: sealed after reset
        bus_rd(IDX, 8'hFF, "R1 index read after reset");
        bus_rd(DAT, 8'hFF, "R6 data read while locked");
        win_chk(1'b0, "R1 window enable after reset");

        // R2: writes while locked are ignored
        bus_wr(DAT, 8'h5A);
        bus_wr(IDX, 8'h12);
        bus_wr(IDX, 8'h55);
        bus_rd(IDX, 8'hFF, "R2 still locked after non-key writes");
        bus_wr(IDX, 8'hAA);
        bus_rd(IDX, 8'h00, "R2 index untouched while locked (R8 cleared)");
        bus_rd(DAT, 8'h00, "R2 reg 0 untouched while locked");

        // R4 / R5
        bus_wr(IDX, 8'h12);
        bus_rd(IDX, 8'h12, "R4 index readback");
        bus_rd(DAT, 8'h00, "R8 reg 0x12 cleared by reset");
        bus_wr(DAT, 8'h3C);
        bus_rd(DAT, 8'h3C, "R5 data readback");
        bus_wr(IDX, 8'h13);
        bus_wr(DAT, 8'hC3);
        bus_rd(DAT, 8'hC3, "R5 reg 0x13 readback");
        bus_wr(IDX, 8'h12);
        bus_rd(DAT, 8'h3C, "R5 reg 0x12 independent of 0x13");

        // R10
        bus_wr(IDX, 8'hAA);
        bus_rd(IDX, 8'hAA, "R10 0xAA as plain index while open");

        // R7
        bus_wr(IDX, 8'hC1);
        bus_wr(DAT, 8'h80);
        win_chk(1'b1, "R7 window on after bit7 set");
        bus_wr(DAT, 8'h7F);
        win_chk(1'b0, "R7 window off after bit7 clear");
        bus_wr(DAT, 8'hFF);
        win_chk(1'b1, "R7 window on again");

        // R9: foreign addresses
        bus_wr(16'h010A, 8'h00);
        bus_wr(16'h0107, 8'h55);
        bus_rd(16'h010A, 8'hFF, "R9 foreign read");
        bus_rd(DAT, 8'hFF, "R9 reg 0xC1 unchanged by foreign write");
        bus_rd(IDX, 8'hC1, "R9 index unchanged / still open");
        win_chk(1'b1, "R9 window unchanged");

        // R3: relock keeps index
        bus_wr(IDX, 8'h55);
        bus_rd(IDX, 8'hFF, "R3 relocked index read");
        bus_rd(DAT, 8'hFF, "R6 relocked data read");
        bus_wr(DAT, 8'h00);
        bus_wr(IDX, 8'hAA);
        bus_rd(IDX, 8'hC1, "R3 index retained across lock");
        bus_rd(DAT, 8'hFF, "R2 data write while relocked ignored");
        win_chk(1'b1, "R2 window kept while relocked");

        // R8: reset clears contents
        do_reset();
        win_chk(1'b0, "R1 window cleared by reset");
        bus_rd(DAT, 8'hFF, "R1 locked after second reset");
        bus_wr(IDX, 8'hAA);
        bus_rd(IDX, 8'h00, "R8 index cleared");
        bus_wr(IDX, 8'hC1);
        bus_rd(DAT, 8'h00, "R8 reg 0xC1 cleared");
        bus_wr(IDX, 8'h12);
        bus_rd(DAT, 8'h00, "R8 reg 0x12 cleared");

        repeat (3) @(posedge clk);
        if (q_exp.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", q_exp.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule